// File: doc/BRIEF.md
# Multiplexed external bus sequencer

This block produces the external memory bus waveforms for a small 8-bit controller core whose program memory is entirely off-chip. It runs on the oscillator clock and counts 12-clock machine cycles, each split into two 6-clock slots. In an ordinary cycle both slots are instruction fetches. Each slot pulses an address latch strobe while the low address byte is driven on the shared low bus, then asserts an active-low program read strobe with the low bus released, and returns the byte sampled from the bus.

When the core asks for an external data transfer, the whole next machine cycle becomes one data access. It has a single address latch pulse, no program read strobes and one long read or write strobe. The high byte lane carries either the upper address byte (16-bit access) or the content of the core's high-port register (8-bit access). The core offers its requests on fixed clock edges, which two boundary outputs mark, and it receives fetched and read bytes as one-clock valid pulses.

Top module: `xbus_seq`

## Requirements
- R1: While rst_ni is low, ale_o is 0, psen_no, rd_no and wr_no are 1, p0_oe_o is 0 and both valid outputs are 0. The first machine cycle starts on the first rising clock edge after release.
- R2: A machine cycle is 12 clocks, phases 0 to 11. slot_end_o is 1 in phases 5 and 11. cycle_end_o is 1 in phase 11 only.
- R3: In a fetch cycle, each 6-clock slot has ale_o high for its first 2 clocks and psen_no low for its last 3 clocks. rd_no and wr_no stay high.
- R4: In a fetch slot, p2_o carries bits 15:8 of the fetch address for the whole slot. p0_o carries bits 7:0 with p0_oe_o high for the first 3 clocks, and p0_oe_o is low while psen_no is low. The fetch address is code_addr_i as sampled on the edge that ends the previous slot.
- R5: The byte on p0_i at the edge where psen_no rises is presented on code_o, with code_valid_o high for exactly the next clock (phase 6 or phase 0).
- R6: A data cycle has ale_o high in phases 0 and 1 only and psen_no high throughout. Its strobe (rd_no for a read, wr_no for a write) is low in phases 5 to 10, which is 3 clocks after ale_o falls, for 6 clocks.
- R7: In a data cycle, p2_o carries address bits 15:8 when data_wide_i was 1, and otherwise follows p2_reg_i. p0_o carries address bits 7:0 in phases 0 to 2.
- R8: On a write, p0_oe_o stays high in phases 3 to 11 and p0_o carries the write byte. On a read, p0_oe_o is low in phases 3 to 11.
- R9: On a read, the byte on p0_i at the edge where rd_no rises is presented on rdata_o, with rdata_valid_o high for phase 11 only.
- R10: data_req_i, data_wr_i, data_wide_i, data_addr_i and data_wdata_i are sampled only on the edge that ends phase 11. Values they take at other times have no effect.
- R11: rd_no, wr_no and psen_no are never low two at a time, and ale_o is never high while any of them is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| code_addr_i | input | 16 | Fetch address for the next slot |
| data_req_i | input | 1 | Make the next machine cycle a data access |
| data_wr_i | input | 1 | 1 = write, 0 = read |
| data_wide_i | input | 1 | 1 = 16-bit address, 0 = 8-bit address |
| data_addr_i | input | 16 | Data access address |
| data_wdata_i | input | 8 | Write byte |
| p2_reg_i | input | 8 | High-port register content for 8-bit accesses |
| p0_i | input | 8 | Low bus input |
| slot_end_o | output | 1 | Last clock of a slot (phases 5, 11) |
| cycle_end_o | output | 1 | Last clock of a machine cycle (phase 11) |
| code_o | output | 8 | Fetched byte |
| code_valid_o | output | 1 | code_o valid, one clock |
| rdata_o | output | 8 | Read byte |
| rdata_valid_o | output | 1 | rdata_o valid, one clock |
| ale_o | output | 1 | Address latch strobe, active high |
| psen_no | output | 1 | Program read strobe, active low |
| rd_no | output | 1 | Data read strobe, active low |
| wr_no | output | 1 | Data write strobe, active low |
| p0_o | output | 8 | Low bus output (address low / write data) |
| p0_oe_o | output | 1 | Low bus drive enable |
| p2_o | output | 8 | High byte lane |

## Verification
The bench runs a long sequence of fetch, read and write cycles in a mixed order. It includes back-to-back data cycles and alternates 8-bit with 16-bit addressing. Every output is compared on every clock against a schedule worked out from the phase number, and an external memory model answers from the latched address. A design that samples at the wrong edge returns the idle bus value instead of the memory byte. A design that keeps the program strobe in data cycles, or moves the data strobe by one clock, mismatches at the strobe edges. A design that drives the high lane from the address during an 8-bit access shows the wrong p2_o byte. Garbage requests are also applied in mid-cycle, so a sequencer that samples them outside phase 11 turns fetch cycles into data cycles.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [1:0] {
    K_IDLE  = 2'd0,
    K_FETCH = 2'd1,
    K_READ  = 2'd2,
    K_WRITE = 2'd3
  } xbus_kind_e;

  typedef struct packed {
    logic ale;
    logic psen_n;
    logic rd_n;
    logic wr_n;
    logic p0_oe;
    logic p0_addr;
    logic cap_code;
    logic cap_data;
  } xbus_ctl_t;

endpackage

// File: rtl/xbus_phase_ctr.sv
module xbus_phase_ctr #(
  parameter int unsigned CYC_LEN  = 12,
  parameter int unsigned HALF_LEN = 6,
  parameter int unsigned PH_W     = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [PH_W-1:0] phase_o,
  output logic            slot_end_o,
  output logic            cyc_end_o
);
  localparam logic [PH_W-1:0] LAST = PH_W'(CYC_LEN - 1);
  localparam logic [PH_W-1:0] MID  = PH_W'(HALF_LEN - 1);

  logic [PH_W-1:0] phase_q;

  // reset parks on the last phase so the first edge opens cycle 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= LAST;
    else if (phase_q == LAST) phase_q <= '0;
    else phase_q <= phase_q + 1'b1;
  end

  assign phase_o    = phase_q;
  assign cyc_end_o  = (phase_q == LAST);
  assign slot_end_o = (phase_q == LAST) || (phase_q == MID);
endmodule

// File: rtl/xbus_strobe_dec.sv
module xbus_strobe_dec
  import xbus_pkg::*;
#(
  parameter int unsigned HALF_LEN = 6,
  parameter int unsigned ALE_LEN  = 2,
  parameter int unsigned PSEN_LEN = 3,
  parameter int unsigned STB_DLY  = 3,
  parameter int unsigned STB_LEN  = 6,
  parameter int unsigned PH_W     = 4
) (
  input  logic [PH_W-1:0] phase_i,
  input  xbus_kind_e      kind_i,
  output xbus_ctl_t       ctl_o
);
  localparam int unsigned ADDR_LEN = ALE_LEN + 1;
  localparam int unsigned PSEN_ON  = HALF_LEN - PSEN_LEN;
  localparam int unsigned STB_ON   = ALE_LEN + STB_DLY;
  localparam int unsigned STB_OFF  = STB_ON + STB_LEN;

  int unsigned ph;
  int unsigned hp;
  logic        stb;

  always_comb begin
    ph  = 32'(phase_i);
    hp  = (ph >= HALF_LEN) ? ph - HALF_LEN : ph;
    stb = (ph >= STB_ON) && (ph < STB_OFF);
    ctl_o = '{ale: 1'b0, psen_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1,
              p0_oe: 1'b0, p0_addr: 1'b0, cap_code: 1'b0, cap_data: 1'b0};
    case (kind_i)
      K_FETCH: begin
        ctl_o.ale      = (hp < ALE_LEN);
        ctl_o.psen_n   = !(hp >= PSEN_ON);
        ctl_o.p0_oe    = (hp < ADDR_LEN);
        ctl_o.p0_addr  = 1'b1;
        ctl_o.cap_code = (hp == HALF_LEN - 1);
      end
      K_READ: begin
        ctl_o.ale      = (ph < ALE_LEN);
        ctl_o.rd_n     = !stb;
        ctl_o.p0_oe    = (ph < ADDR_LEN);
        ctl_o.p0_addr  = (ph < ADDR_LEN);
        ctl_o.cap_data = (ph == STB_OFF - 1);
      end
      K_WRITE: begin
        ctl_o.ale     = (ph < ALE_LEN);
        ctl_o.wr_n    = !stb;
        ctl_o.p0_oe   = 1'b1;
        ctl_o.p0_addr = (ph < ADDR_LEN);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/xbus_capture.sv
module xbus_capture #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_code_i,
  input  logic          cap_data_i,
  input  logic [DW-1:0] bus_i,
  output logic [DW-1:0] code_o,
  output logic          code_valid_o,
  output logic [DW-1:0] rdata_o,
  output logic          rdata_valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_o        <= '0;
      code_valid_o  <= 1'b0;
      rdata_o       <= '0;
      rdata_valid_o <= 1'b0;
    end else begin
      code_valid_o  <= cap_code_i;
      rdata_valid_o <= cap_data_i;
      if (cap_code_i) code_o  <= bus_i;
      if (cap_data_i) rdata_o <= bus_i;
    end
  end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int unsigned AW       = 16,
  parameter int unsigned DW       = 8,
  parameter int unsigned HALF_LEN = 6,
  parameter int unsigned ALE_LEN  = 2,
  parameter int unsigned PSEN_LEN = 3,
  parameter int unsigned STB_DLY  = 3,
  parameter int unsigned STB_LEN  = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    code_addr_i,
  input  logic             data_req_i,
  input  logic             data_wr_i,
  input  logic             data_wide_i,
  input  logic [AW-1:0]    data_addr_i,
  input  logic [DW-1:0]    data_wdata_i,
  input  logic [AW-DW-1:0] p2_reg_i,
  input  logic [DW-1:0]    p0_i,
  output logic             slot_end_o,
  output logic             cycle_end_o,
  output logic [DW-1:0]    code_o,
  output logic             code_valid_o,
  output logic [DW-1:0]    rdata_o,
  output logic             rdata_valid_o,
  output logic             ale_o,
  output logic             psen_no,
  output logic             rd_no,
  output logic             wr_no,
  output logic [DW-1:0]    p0_o,
  output logic             p0_oe_o,
  output logic [AW-DW-1:0] p2_o
);
  localparam int unsigned CYC_LEN = 2 * HALF_LEN;
  localparam int unsigned PH_W    = $clog2(CYC_LEN);

  logic [PH_W-1:0] phase;
  logic            slot_end;
  logic            cyc_end;
  xbus_kind_e      kind_q;
  logic            wide_q;
  logic [AW-1:0]   daddr_q;
  logic [DW-1:0]   wdata_q;
  logic [AW-1:0]   faddr_q;
  xbus_ctl_t       ctl;

  xbus_phase_ctr #(
    .CYC_LEN (CYC_LEN),
    .HALF_LEN(HALF_LEN),
    .PH_W    (PH_W)
  ) u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .phase_o   (phase),
    .slot_end_o(slot_end),
    .cyc_end_o (cyc_end)
  );

  // requests only taken at the machine cycle boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q  <= K_IDLE;
      wide_q  <= 1'b0;
      daddr_q <= '0;
      wdata_q <= '0;
      faddr_q <= '0;
    end else begin
      if (cyc_end) begin
        kind_q <= data_req_i ? (data_wr_i ? K_WRITE : K_READ) : K_FETCH;
        if (data_req_i) begin
          wide_q  <= data_wide_i;
          daddr_q <= data_addr_i;
          wdata_q <= data_wdata_i;
        end
      end
      if (slot_end) faddr_q <= code_addr_i;
    end
  end

  xbus_strobe_dec #(
    .HALF_LEN(HALF_LEN),
    .ALE_LEN (ALE_LEN),
    .PSEN_LEN(PSEN_LEN),
    .STB_DLY (STB_DLY),
    .STB_LEN (STB_LEN),
    .PH_W    (PH_W)
  ) u_dec (
    .phase_i(phase),
    .kind_i (kind_q),
    .ctl_o  (ctl)
  );

  xbus_capture #(
    .DW(DW)
  ) u_cap (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cap_code_i   (ctl.cap_code),
    .cap_data_i   (ctl.cap_data),
    .bus_i        (p0_i),
    .code_o       (code_o),
    .code_valid_o (code_valid_o),
    .rdata_o      (rdata_o),
    .rdata_valid_o(rdata_valid_o)
  );

  logic is_fetch;
  logic is_data;
  assign is_fetch = (kind_q == K_FETCH);
  assign is_data  = (kind_q == K_READ) || (kind_q == K_WRITE);

  assign slot_end_o  = slot_end;
  assign cycle_end_o = cyc_end;
  assign ale_o       = ctl.ale;
  assign psen_no     = ctl.psen_n;
  assign rd_no       = ctl.rd_n;
  assign wr_no       = ctl.wr_n;
  assign p0_oe_o     = ctl.p0_oe;

  always_comb begin
    if (is_fetch)         p0_o = faddr_q[DW-1:0];
    else if (ctl.p0_addr) p0_o = daddr_q[DW-1:0];
    else                  p0_o = wdata_q;
  end

  // 8-bit data accesses leave the high lane showing the port register
  always_comb begin
    if (is_fetch)               p2_o = faddr_q[AW-1:DW];
    else if (is_data && wide_q) p2_o = daddr_q[AW-1:DW];
    else                        p2_o = p2_reg_i;
  end
endmodule

// File: rtl/xbus_seq_chk.sv
module xbus_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ale_o,
  input logic psen_no,
  input logic rd_no,
  input logic wr_no,
  input logic p0_oe_o,
  input logic code_valid_o,
  input logic rdata_valid_o,
  input logic slot_end_o,
  input logic cycle_end_o
);
  p_strobe_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_no || wr_no) && (psen_no || (rd_no && wr_no)));

  p_ale_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (psen_no && rd_no && wr_no));

  p_ale_width_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ale_o) |-> ($past(ale_o, 2) && !$past(ale_o, 3)));

  p_stb_delay_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_no) |-> ($past(ale_o, 4) && !$past(ale_o, 3)));

  p_wr_delay_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wr_no) |-> ($past(ale_o, 4) && !$past(ale_o, 3)));

  // R4 and R8: bus released under a read strobe, driven under a write strobe
  p_bus_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_no || !psen_no) |-> !p0_oe_o);

  p_bus_drive_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_no |-> p0_oe_o);

  p_code_edge_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_valid_o |-> $rose(psen_no));

  p_rdata_edge_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_valid_o |-> $rose(rd_no));

  p_cyc_in_slot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_end_o |-> slot_end_o);

  p_slot_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_end_o |=> !slot_end_o);
endmodule

bind xbus_seq xbus_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ale_o        (ale_o),
  .psen_no      (psen_no),
  .rd_no        (rd_no),
  .wr_no        (wr_no),
  .p0_oe_o      (p0_oe_o),
  .code_valid_o (code_valid_o),
  .rdata_valid_o(rdata_valid_o),
  .slot_end_o   (slot_end_o),
  .cycle_end_o  (cycle_end_o)
);

// File: tb/xbus_seq_bench.sv
module xbus_seq_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NCYC = 48;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [15:0] code_addr_i;
  logic        data_req_i, data_wr_i, data_wide_i;
  logic [15:0] data_addr_i;
  logic [7:0]  data_wdata_i, p2_reg_i, p0_i;
  logic        slot_end_o, cycle_end_o, code_valid_o, rdata_valid_o;
  logic [7:0]  code_o, rdata_o, p0_o, p2_o;
  logic        ale_o, psen_no, rd_no, wr_no, p0_oe_o;

  int checks = 0;
  int errs   = 0;
  bit done   = 0;

  always #2 clk_i = ~clk_i;

  xbus_seq u_xbus_seq (.*);

  function automatic int kind_of(int m);  // 0 fetch, 1 read, 2 write
    int r = (m * 7 + 3) % 5;
    return (r <= 1) ? 0 : (r == 3) ? 2 : 1;
  endfunction
  function automatic logic [15:0] caddr(int s); return 16'(s * 1031 + 17); endfunction
  function automatic logic [15:0] daddr(int m); return 16'(m * 9371 + 291); endfunction
  function automatic logic [7:0]  wdat(int m);  return 8'(m * 13 + 7); endfunction
  function automatic logic [7:0]  p2v(int m);   return 8'(m * 29 + 64); endfunction
  function automatic logic        wide(int m);  return m[1]; endfunction
  function automatic logic [7:0]  mem(logic [15:0] a);
    return a[7:0] ^ (a[15:8] * 8'd3) ^ 8'h5A;
  endfunction

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic drive_cycle(int m);
    data_req_i   = (kind_of(m) != 0);
    data_wr_i    = (kind_of(m) == 2);
    data_wide_i  = wide(m);
    data_addr_i  = daddr(m);
    data_wdata_i = wdat(m);
    p2_reg_i     = p2v(m);
  endtask

  // R10: mid-cycle junk that must never be taken
  task automatic drive_junk();
    data_req_i   = 1'b1;
    data_wr_i    = ~data_wr_i;
    data_wide_i  = ~data_wide_i;
    data_addr_i  = 16'hBEEF;
    data_wdata_i = 8'hA5;
  endtask

  initial begin
    logic [7:0] lat = '0;
    rst_ni = 1'b0;
    p0_i = '0;
    code_addr_i = caddr(0);
    drive_cycle(0);
    repeat (3) @(negedge clk_i);
    chk("R1", "ale", ale_o, 0);
    chk("R1", "psen", psen_no, 1);
    chk("R1", "rd", rd_no, 1);
    chk("R1", "wr", wr_no, 1);
    chk("R1", "oe", p0_oe_o, 0);
    chk("R1", "code_valid", code_valid_o, 0);
    chk("R1", "rdata_valid", rdata_valid_o, 0);
    rst_ni = 1'b1;
    for (int n = 1; n <= NCYC * 12; n++) begin
      int p, m, k, h, s;
      logic eale, epsen, erd, ewr, eoe, stb, ecv, erv;
      logic [7:0] ep0, ep2;
      string tk, tp;
      @(negedge clk_i);
      // external memory model
      if (ale_o) lat = p0_o;
      p0_i = (!psen_no || !rd_no) ? mem({p2_o, lat}) : 8'h00;

      p = (n - 1) % 12;
      m = (n - 1) / 12;
      k = kind_of(m);
      h = p % 6;
      s = 2 * m + ((p >= 6) ? 1 : 0);
      if (k == 0) begin
        eale = (h < 2); epsen = !(h >= 3); erd = 1; ewr = 1; eoe = (h < 3);
        ep0 = caddr(s)[7:0]; ep2 = caddr(s)[15:8];
        tk = "R3"; tp = "R4";
      end else begin
        stb = (p >= 5) && (p <= 10);
        eale = (p < 2); epsen = 1; erd = !(k == 1 && stb); ewr = !(k == 2 && stb);
        eoe = (p < 3) || (k == 2);
        ep0 = (p < 3) ? daddr(m)[7:0] : wdat(m);
        ep2 = wide(m) ? daddr(m)[15:8] : p2v(m);
        tk = "R6"; tp = (p < 3) ? "R7" : "R8";
      end
      chk(tk, "ale", ale_o, eale);
      chk(tk, "psen", psen_no, epsen);
      chk((k == 0) ? "R10" : "R6", "rd", rd_no, erd);
      chk((k == 0) ? "R10" : "R6", "wr", wr_no, ewr);
      chk(tp, "p0_oe", p0_oe_o, eoe);
      if (eoe) chk(tp, "p0", p0_o, ep0);
      chk((k == 0) ? "R4" : "R7", "p2", p2_o, ep2);
      chk("R2", "slot_end", slot_end_o, (p == 5) || (p == 11));
      chk("R2", "cycle_end", cycle_end_o, p == 11);

      ecv = (p == 6 && k == 0) || (p == 0 && m >= 1 && kind_of(m - 1) == 0);
      chk("R5", "code_valid", code_valid_o, ecv);
      if (ecv) chk("R5", "code", code_o, mem(caddr((p == 6) ? 2 * m : 2 * m - 1)));
      erv = (p == 11) && (k == 1);
      chk("R9", "rdata_valid", rdata_valid_o, erv);
      if (erv) chk("R9", "rdata", rdata_o,
                   mem(wide(m) ? daddr(m) : {p2v(m), daddr(m)[7:0]}));

      if (n % 6 == 0) code_addr_i = caddr(n / 6);
      if (n % 12 == 0) drive_cycle(n / 12);
      else if (n % 12 == 6) drive_junk();
    end
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      checks++;
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule